// File: doc/BRIEF.md
# SD Host Interrupt Status Unit

This block keeps the interrupt bookkeeping of an SD host controller. The command and data engines raise single-cycle event pulses for command completion, transfer completion and ten kinds of error. Each event is captured in a sticky status bit, but only if the matching status-enable bit is on. Software reads the status registers through a small register port and clears bits by writing ones. A single interrupt line goes high when any status bit is set whose signal-enable bit is also on.

The unit also carries the two self-clearing software reset bits for the command line and the data line. Writing a reset bit starts a fixed hold window. During that window the line's in-progress flag and the status bits of that line are forced to zero. Software polls the bit until it reads 0. A qualified-error output follows the rule that a completed transfer overrides a data-timeout report, so that the timeout is not treated as an error in that case.

Top module: `sd_irq_status_unit`

## Requirements
- R1: Four 16-bit enable registers are read/write and reset to 0: normal status enable (address 2), error status enable (address 3), normal signal enable (address 4) and error signal enable (address 5). All status registers also reset to 0.
- R2: Writing to normal status (address 0) or error status (address 1) clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R3: A status bit is set only when its event pulse arrives while its status-enable bit is 1. An event whose enable bit is 0 leaves the bit at 0.
- R4: When an event and a write-1 clear hit the same bit in the same cycle, the bit ends up set.
- R5: In normal status, bit 0 is command complete and bit 1 is transfer complete. Bit 15 is a read-only summary that is 1 exactly when (error status AND error status enable) is nonzero.
- R6: Error status bits 0 to 9 are, in order: command timeout, command CRC, command end-bit, command index, data timeout, data CRC, data end-bit, current limit, auto-CMD12 error and ADMA error. Error event input bit i sets error status bit i.
- R7: `err_qual` is 1 when some error status bit is set. The one exception: if the only error set is data timeout (bit 4) and transfer complete is set, `err_qual` is 0.
- R8: `irq` equals the OR of (normal status view AND normal signal enable) and (error status AND error signal enable), delayed by one clock.
- R9: The software reset register is at address 6, with bit 0 for the command line and bit 1 for the data line. After a write of 1, the bit reads 1 for exactly 4 cycles and then reads 0.
- R10: While a line reset runs, that line's busy flag is cleared. Address 7 reads bit 0 as command-line busy and bit 1 as data-line busy. A command reset clears normal bit 0 and error bits 0-3 and 8. A data reset clears normal bit 1 and error bits 4-6 and 9. Error bit 7 is left alone by both resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_done_evt | input | 1 | Command complete pulse |
| xfer_done_evt | input | 1 | Transfer complete pulse |
| err_evt | input | 10 | Error event pulses, one per error source |
| cmd_start | input | 1 | Command line becomes busy |
| cmd_end | input | 1 | Command line becomes free |
| dat_start | input | 1 | Data line becomes busy |
| dat_end | input | 1 | Data line becomes free |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| irq | output | 1 | Registered interrupt request |
| err_qual | output | 1 | Qualified error flag |
| cmd_busy | output | 1 | Command line in progress |
| dat_busy | output | 1 | Data line in progress |

## Verification
The bench aims at the places where a sticky-bit design usually goes wrong:
- an event that collides with a clear (a design that gives the clear priority loses the interrupt);
- an event whose enable bit is off (a design that ignores the enable latches it anyway);
- a write of zeros (a toggle or plain-write design corrupts the other bits).

It also checks the exact bit assigned to every error source and the one-cycle delay of the interrupt.

For software reset, the bench counts the cycles the reset bit stays at 1 and checks which status bits survive each line reset. A design that clears the wrong set of bits, or never releases the bit, shows up there.

For the qualified-error flag, the bench sets a data timeout first on its own and then together with transfer complete. A design without the override reports a spurious error in the second case.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
  localparam int REG_W   = 16;
  localparam int NUM_ERR = 10;
  localparam int ADDR_W  = 3;
  localparam int NLINES  = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_NSTS = 3'd0,
    A_ESTS = 3'd1,
    A_NSEN = 3'd2,
    A_ESEN = 3'd3,
    A_NIEN = 3'd4,
    A_EIEN = 3'd5,
    A_SRST = 3'd6,
    A_LINE = 3'd7
  } reg_addr_e;

  localparam int NB_CMD    = 0;
  localparam int NB_XFER   = 1;
  localparam int NB_ERRSUM = 15;
  localparam int EB_DAT_TO = 4;

  localparam logic [REG_W-1:0] NRM_IMPL     = 16'h0003;
  localparam logic [REG_W-1:0] ERR_IMPL     = REG_W'((1 << NUM_ERR) - 1);
  localparam logic [REG_W-1:0] CMD_NRM_MASK = 16'h0001;
  localparam logic [REG_W-1:0] DAT_NRM_MASK = 16'h0002;
  localparam logic [REG_W-1:0] CMD_ERR_MASK = 16'h010F;
  localparam logic [REG_W-1:0] DAT_ERR_MASK = 16'h0270;

  // kill beats event, event beats clear
  function automatic logic [REG_W-1:0] sts_next(
    input logic [REG_W-1:0] cur,
    input logic [REG_W-1:0] evt,
    input logic [REG_W-1:0] en,
    input logic [REG_W-1:0] clr,
    input logic [REG_W-1:0] kill
  );
    return ((cur & ~clr) | (evt & en)) & ~kill;
  endfunction

  function automatic logic err_summary(
    input logic [REG_W-1:0] ests,
    input logic [REG_W-1:0] een
  );
    return |(ests & een);
  endfunction

  // transfer complete hides a data-timeout report
  function automatic logic qual_err(
    input logic [REG_W-1:0] ests,
    input logic             xfer_done
  );
    logic [REG_W-1:0] m;
    m = ests;
    if (xfer_done) m[EB_DAT_TO] = 1'b0;
    return |m;
  endfunction
endpackage

// File: rtl/sdirq_status_bank.sv
module sdirq_status_bank
  import sdirq_pkg::*;
#(
  parameter logic [REG_W-1:0] IMPL = 16'hFFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] evt,
  input  logic [REG_W-1:0] en,
  input  logic [REG_W-1:0] clr,
  input  logic [REG_W-1:0] kill,
  output logic [REG_W-1:0] sts
);
  always_ff @(posedge clk) begin
    if (!rst_n) sts <= '0;
    else        sts <= sts_next(sts, evt, en, clr, kill) & IMPL;
  end
endmodule

// File: rtl/sdirq_line_ctl.sv
module sdirq_line_ctl #(
  parameter int HOLD = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rst_go,
  input  logic seg_begin,
  input  logic seg_end,
  output logic rst_active,
  output logic busy
);
  localparam int CW = $clog2(HOLD + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)         cnt <= '0;
    else if (rst_go)    cnt <= CW'(HOLD);
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign rst_active = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)          busy <= 1'b0;
    else if (rst_active) busy <= 1'b0;
    else if (seg_begin)  busy <= 1'b1;
    else if (seg_end)    busy <= 1'b0;
  end
endmodule

// File: rtl/sdirq_irq_gen.sv
module sdirq_irq_gen
  import sdirq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [REG_W-1:0] nview,
  input  logic [REG_W-1:0] nsig_en,
  input  logic [REG_W-1:0] ests,
  input  logic [REG_W-1:0] esig_en,
  output logic             irq
);
  logic irq_d;
  assign irq_d = (|(nview & nsig_en)) | (|(ests & esig_en));

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/sd_irq_status_unit.sv
module sd_irq_status_unit
  import sdirq_pkg::*;
#(
  parameter int RST_HOLD = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_done_evt,
  input  logic               xfer_done_evt,
  input  logic [NUM_ERR-1:0] err_evt,
  input  logic               cmd_start,
  input  logic               cmd_end,
  input  logic               dat_start,
  input  logic               dat_end,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  output logic               irq,
  output logic               err_qual,
  output logic               cmd_busy,
  output logic               dat_busy
);
  logic [REG_W-1:0] nsts_en, ests_en, nsig_en, esig_en;
  logic [REG_W-1:0] nsts, ests, nview;
  logic [REG_W-1:0] nevt, eevt, nclr, eclr, nkill, ekill;
  logic [NLINES-1:0] srst_go, srst_act, line_beg, line_end, line_busy;
  logic wr_nsts, wr_ests, wr_srst;

  assign wr_nsts = reg_wr && (reg_addr == A_NSTS);
  assign wr_ests = reg_wr && (reg_addr == A_ESTS);
  assign wr_srst = reg_wr && (reg_addr == A_SRST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nsts_en <= '0;
      ests_en <= '0;
      nsig_en <= '0;
      esig_en <= '0;
    end else if (reg_wr) begin
      case (reg_addr_e'(reg_addr))
        A_NSEN:  nsts_en <= reg_wdata;
        A_ESEN:  ests_en <= reg_wdata;
        A_NIEN:  nsig_en <= reg_wdata;
        A_EIEN:  esig_en <= reg_wdata;
        default: ;
      endcase
    end
  end

  assign line_beg = {dat_start, cmd_start};
  assign line_end = {dat_end, cmd_end};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    assign srst_go[g] = wr_srst && reg_wdata[g];
    sdirq_line_ctl #(.HOLD(RST_HOLD)) u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .rst_go     (srst_go[g]),
      .seg_begin  (line_beg[g]),
      .seg_end    (line_end[g]),
      .rst_active (srst_act[g]),
      .busy       (line_busy[g])
    );
  end

  assign cmd_busy = line_busy[0];
  assign dat_busy = line_busy[1];

  assign nkill = ({REG_W{srst_act[0]}} & CMD_NRM_MASK) | ({REG_W{srst_act[1]}} & DAT_NRM_MASK);
  assign ekill = ({REG_W{srst_act[0]}} & CMD_ERR_MASK) | ({REG_W{srst_act[1]}} & DAT_ERR_MASK);

  assign nevt = REG_W'({xfer_done_evt, cmd_done_evt});
  assign eevt = REG_W'(err_evt);
  assign nclr = wr_nsts ? reg_wdata : '0;
  assign eclr = wr_ests ? reg_wdata : '0;

  sdirq_status_bank #(.IMPL(NRM_IMPL)) u_nrm (
    .clk (clk), .rst_n (rst_n), .evt (nevt), .en (nsts_en),
    .clr (nclr), .kill (nkill), .sts (nsts)
  );

  sdirq_status_bank #(.IMPL(ERR_IMPL)) u_err (
    .clk (clk), .rst_n (rst_n), .evt (eevt), .en (ests_en),
    .clr (eclr), .kill (ekill), .sts (ests)
  );

  always_comb begin
    nview = nsts;
    nview[NB_ERRSUM] = err_summary(ests, ests_en);
  end

  assign err_qual = qual_err(ests, nsts[NB_XFER]);

  sdirq_irq_gen u_irq (
    .clk (clk), .rst_n (rst_n), .nview (nview), .nsig_en (nsig_en),
    .ests (ests), .esig_en (esig_en), .irq (irq)
  );

  always_comb begin
    case (reg_addr_e'(reg_addr))
      A_NSTS:  reg_rdata = nview;
      A_ESTS:  reg_rdata = ests;
      A_NSEN:  reg_rdata = nsts_en;
      A_ESEN:  reg_rdata = ests_en;
      A_NIEN:  reg_rdata = nsig_en;
      A_EIEN:  reg_rdata = esig_en;
      A_SRST:  reg_rdata = REG_W'(srst_act);
      A_LINE:  reg_rdata = REG_W'(line_busy);
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdirq_checker.sv
module sdirq_checker
  import sdirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [REG_W-1:0]  ests,
  input logic [REG_W-1:0]  nsts,
  input logic [REG_W-1:0]  nview,
  input logic [REG_W-1:0]  eevt,
  input logic [REG_W-1:0]  ests_en,
  input logic [REG_W-1:0]  eclr,
  input logic [REG_W-1:0]  ekill,
  input logic [REG_W-1:0]  nsig_en,
  input logic [REG_W-1:0]  esig_en,
  input logic [NLINES-1:0] srst_act,
  input logic              cmd_busy,
  input logic              irq,
  input logic              err_qual
);
  AST_LATCH_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    ((ests & ~$past(ests) & ~$past(eevt & ests_en)) == '0)); // R3

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (eclr == '0 && ekill == '0) |=> ((ests & $past(ests)) == $past(ests))); // R2

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ((eevt & ests_en & ~ekill) != '0) |=>
      ((ests & $past(eevt & ests_en & ~ekill)) == $past(eevt & ests_en & ~ekill))); // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq == $past((|(nview & nsig_en)) || (|(ests & esig_en)))); // R8

  AST_CMD_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(srst_act[0]) |-> (!cmd_busy && ((ests & CMD_ERR_MASK) == '0) && !nsts[NB_CMD])); // R10

  AST_QUAL_NEEDS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    err_qual |-> (ests != '0)); // R7
endmodule

bind sd_irq_status_unit sdirq_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ests     (ests),
  .nsts     (nsts),
  .nview    (nview),
  .eevt     (eevt),
  .ests_en  (ests_en),
  .eclr     (eclr),
  .ekill    (ekill),
  .nsig_en  (nsig_en),
  .esig_en  (esig_en),
  .srst_act (srst_act),
  .cmd_busy (cmd_busy),
  .irq      (irq),
  .err_qual (err_qual)
);

// File: tb/sd_irq_status_unit_tb.sv
module sd_irq_status_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_done_evt = 0, xfer_done_evt = 0;
  logic [9:0] err_evt = '0;
  logic cmd_start = 0, cmd_end = 0, dat_start = 0, dat_end = 0;
  logic reg_wr = 0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic irq, err_qual, cmd_busy, dat_busy;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  sd_irq_status_unit dut_i (
    .clk, .rst_n, .cmd_done_evt, .xfer_done_evt, .err_evt,
    .cmd_start, .cmd_end, .dat_start, .dat_end,
    .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .irq, .err_qual, .cmd_busy, .dat_busy
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // all tasks enter and leave at a falling edge
  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic chk_rd(input string tag, input logic [2:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic pulse(input logic c, input logic x, input logic [9:0] e);
    cmd_done_evt = c; xfer_done_evt = x; err_evt = e;
    @(posedge clk); @(negedge clk);
    cmd_done_evt = 0; xfer_done_evt = 0; err_evt = '0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 8; a++) chk_rd("R1 reset value", 3'(a), 16'h0);
    chk("R8 irq after reset", 16'(irq), 16'h0);
  endtask

  task automatic t_enables();
    wr(3'd2, 16'hA5A5); wr(3'd3, 16'h03FF); wr(3'd4, 16'h8003); wr(3'd5, 16'h0155);
    chk_rd("R1 nsts_en", 3'd2, 16'hA5A5);
    chk_rd("R1 ests_en", 3'd3, 16'h03FF);
    chk_rd("R1 nsig_en", 3'd4, 16'h8003);
    chk_rd("R1 esig_en", 3'd5, 16'h0155);
    wr(3'd4, 16'h0); wr(3'd5, 16'h0); wr(3'd2, 16'h0003);
  endtask

  task automatic t_err_order();
    wr(3'd3, 16'h03FF);
    for (int i = 0; i < 10; i++) begin
      pulse(0, 0, 10'(1 << i));
      chk_rd("R6 error bit position", 3'd1, 16'(1 << i));
      wr(3'd1, 16'(1 << i));
      chk_rd("R2 clear single bit", 3'd1, 16'h0);
    end
  endtask

  task automatic t_masked();
    wr(3'd3, 16'h0); wr(3'd2, 16'h0);
    pulse(1, 1, 10'h3FF);
    chk_rd("R3 masked errors", 3'd1, 16'h0);
    chk_rd("R3 masked normal", 3'd0, 16'h0);
    wr(3'd3, 16'h0004);
    pulse(0, 0, 10'h3FF);
    chk_rd("R3 partial enable", 3'd1, 16'h0004);
    wr(3'd1, 16'hFFFF); wr(3'd2, 16'h0003); wr(3'd3, 16'h03FF);
  endtask

  task automatic t_w1c();
    pulse(0, 0, 10'h0F0);
    chk_rd("R2 set", 3'd1, 16'h00F0);
    wr(3'd1, 16'h0000);
    chk_rd("R2 write zero keeps", 3'd1, 16'h00F0);
    wr(3'd1, 16'h0030);
    chk_rd("R2 partial clear", 3'd1, 16'h00C0);
    wr(3'd1, 16'hFFFF);
    chk_rd("R2 full clear", 3'd1, 16'h0000);
  endtask

  task automatic t_collide();
    pulse(0, 0, 10'h001);
    err_evt = 10'h001; reg_wr = 1; reg_addr = 3'd1; reg_wdata = 16'h0001;
    @(posedge clk); @(negedge clk);
    err_evt = '0; reg_wr = 0;
    chk_rd("R4 event beats clear", 3'd1, 16'h0001);
    wr(3'd1, 16'h0001);
    chk_rd("R4 later clear works", 3'd1, 16'h0000);
  endtask

  task automatic t_summary();
    pulse(1, 0, '0);
    chk_rd("R5 command complete bit0", 3'd0, 16'h0001);
    pulse(0, 1, '0);
    chk_rd("R5 transfer complete bit1", 3'd0, 16'h0003);
    wr(3'd0, 16'h0003);
    pulse(0, 0, 10'h020);
    chk_rd("R5 summary set", 3'd0, 16'h8000);
    wr(3'd3, 16'h0);
    chk_rd("R5 summary follows enable", 3'd0, 16'h0000);
    wr(3'd3, 16'h03FF);
    wr(3'd0, 16'h8000);
    chk_rd("R5 summary not writable", 3'd0, 16'h8000);
    wr(3'd1, 16'hFFFF);
    chk_rd("R5 summary clears", 3'd0, 16'h0000);
  endtask

  task automatic t_qual();
    pulse(0, 0, 10'h010);
    chk("R7 timeout alone", 16'(err_qual), 16'h1);
    pulse(0, 1, '0);
    chk("R7 transfer hides timeout", 16'(err_qual), 16'h0);
    pulse(0, 0, 10'h020);
    chk("R7 crc still error", 16'(err_qual), 16'h1);
    wr(3'd1, 16'hFFFF); wr(3'd0, 16'h0003);
    chk("R7 no error", 16'(err_qual), 16'h0);
  endtask

  task automatic t_irq();
    wr(3'd4, 16'h0001);
    pulse(1, 0, '0);
    chk("R8 irq not yet", 16'(irq), 16'h0);
    @(negedge clk);
    chk("R8 irq one cycle later", 16'(irq), 16'h1);
    wr(3'd0, 16'h0001);
    chk("R8 irq still high", 16'(irq), 16'h1);
    @(negedge clk);
    chk("R8 irq dropped", 16'(irq), 16'h0);
    wr(3'd4, 16'h0); wr(3'd5, 16'h0004);
    pulse(0, 0, 10'h002);
    @(negedge clk);
    chk("R8 unsignalled error no irq", 16'(irq), 16'h0);
    pulse(0, 0, 10'h004);
    @(negedge clk);
    chk("R8 error irq", 16'(irq), 16'h1);
    wr(3'd5, 16'h0); wr(3'd1, 16'hFFFF);
    @(negedge clk);
    chk("R8 irq idle", 16'(irq), 16'h0);
  endtask

  task automatic t_srst();
    cmd_start = 1; dat_start = 1;
    @(posedge clk); @(negedge clk);
    cmd_start = 0; dat_start = 0;
    chk_rd("R10 both lines busy", 3'd7, 16'h0003);
    pulse(1, 1, 10'h3FF);
    wr(3'd6, 16'h0001);
    chk_rd("R9 cmd reset bit set", 3'd6, 16'h0001);
    for (int k = 1; k < 4; k++) begin
      @(negedge clk);
      chk_rd("R9 cmd reset held", 3'd6, 16'h0001);
    end
    @(negedge clk);
    chk_rd("R9 cmd reset self-clears", 3'd6, 16'h0000);
    chk_rd("R10 cmd line freed", 3'd7, 16'h0002);
    chk_rd("R10 cmd errors cleared", 3'd1, 16'h02F0);
    chk_rd("R10 cmd complete cleared", 3'd0, 16'h8002);
    wr(3'd6, 16'h0002);
    for (int k = 1; k < 5; k++) @(negedge clk);
    chk_rd("R9 data reset self-clears", 3'd6, 16'h0000);
    chk_rd("R10 data line freed", 3'd7, 16'h0000);
    chk_rd("R10 data errors cleared", 3'd1, 16'h0080);
    chk_rd("R10 transfer complete cleared", 3'd0, 16'h8000);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_err_order();
    t_masked();
    t_w1c();
    t_collide();
    t_summary();
    t_qual();
    t_irq();
    t_srst();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      vectors++; miscompares++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule